// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds one binary prescaler that serves two consumers. A configuration input gives it either to an 8-bit event timer or to a watchdog counter. The consumer that does not hold the prescaler runs without division. The timer takes its events from one of two sources. The first is the core clock, which gives one event per cycle. The second is an external pin, passed through a synchronizer and counted on a selectable edge. The watchdog steps on pulses from its own slow oscillator. A software clear strobe restarts the watchdog and also empties the prescaler.

The configuration inputs are captured in registers that reset to a defined state. A cycle in which the owner, the timer source or the pin edge differs from the captured value is a reconfiguration cycle. In that cycle the prescaler is emptied and every count step is held off. Reconfiguration therefore never creates a count of its own. This holds most importantly for the watchdog at 1:1, where a single false count could trigger a reset. The pin edge detector compares raw synchronized pin levels. A change of edge polarity alone can never look like an edge.

Top module: `shared_tick_prescaler`

## Requirements
- R1: While reset is asserted, and on its release, `tmr_count` is 0 and `tmr_ovf` and `wdt_reset` are low. The captured configuration resets to watchdog ownership, external source, rising edge and rate 7.
- R2: With internal source (`ext_src`=0) and no prescaler on the timer, `tmr_count` rises by one every clock cycle. It wraps from 255 to 0, and `tmr_ovf` is high for exactly the one cycle in which the count reads 0 after the wrap.
- R3: With `owner_wdt`=0 the timer advances once per 2^(`rate_sel`+1) source events, giving ratios 2 to 256.
- R4: With `ext_src`=1 a timer source event is a rising pin edge when `fall_edge`=0 and a falling pin edge when `fall_edge`=1. An edge of the other direction has no effect on `tmr_count`.
- R5: With `owner_wdt`=1 the watchdog advances once per 2^`rate_sel` pulses of `wdt_tick`. Rate 0 passes every pulse through.
- R6: After 256 watchdog steps from a clear, `wdt_reset` is high for exactly one cycle.
- R7: `wdt_clear` resets both the watchdog count and the prescaler count. In the cycle after the clear, `wdt_reset` is low.
- R8: Changing `owner_wdt`, `ext_src` or `fall_edge` produces no timer step, no overflow and no watchdog step, at either pin level and in either direction of reassignment.
- R9: The consumer without the prescaler is undivided. When the timer holds the prescaler, the watchdog steps once for every `wdt_tick`. When the watchdog holds it, the timer steps once for every source event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| owner_wdt | input | 1 | 1 gives the prescaler to the watchdog, 0 to the timer |
| rate_sel | input | 3 | Prescale rate code |
| ext_src | input | 1 | 1 selects the external pin as timer source, 0 the core clock |
| fall_edge | input | 1 | 1 counts falling pin edges, 0 rising |
| ext_pin | input | 1 | Asynchronous external event pin |
| wdt_tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| wdt_clear | input | 1 | Watchdog clear strobe (also empties the prescaler) |
| tmr_count | output | 8 | Timer count |
| tmr_ovf | output | 1 | One-cycle pulse on timer wrap |
| wdt_reset | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The hardest case to reach is a watchdog one step away from time-out at 1:1 while the prescaler is reassigned back and forth. The hazard arises with the pin held at the level that a polarity-based detector would read as an edge. The stimulus clears the watchdog and feeds exactly 255 ticks to bring it to the brink. It then sets the pin high, and later low, and walks the owner and edge settings through all four transitions. The check requires no reset and an unchanged timer. A single further tick must then give exactly one time-out. Edge direction is checked halfway through each pin pulse, so that a count on the wrong edge shows before the next edge arrives.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic {
      OWNER_TMR = 1'b0,
      OWNER_WDT = 1'b1
   } owner_e;

   typedef struct packed {
      owner_e owner;
      logic   ext_src;
      logic   fall;
   } tps_cfg_t;

   localparam tps_cfg_t CFG_RESET = '{owner: OWNER_WDT, ext_src: 1'b1, fall: 1'b0};
endpackage

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall,
   input  logic hold,
   output logic pulse
);
   logic cur;
   logic prev;

   generate
      if (SYNC_N == 1) begin : g_single
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b0;
            else        s0 <= pin;
         end
         assign cur = s0;
      end else begin : g_chain
         logic [SYNC_N-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[SYNC_N-2:0], pin};
         end
         assign cur = sr[SYNC_N-1];
      end
   endgenerate

   // previous level follows the raw level; a hold cycle re-arms without a pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end

   logic rise_d, fall_d;
   assign rise_d = cur & ~prev;
   assign fall_d = ~cur & prev;
   assign pulse  = ~hold & (fall ? fall_d : rise_d);
endmodule

// File: rtl/tps_divider.sv
module tps_divider #(
   parameter int PS_W = 8,
   parameter int SH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            in_pulse,
   input  logic [SH_W-1:0] shift,
   output logic            out_pulse
);
   logic [PS_W-1:0] cnt;
   logic [PS_W-1:0] mask;

   assign mask      = ~({PS_W{1'b1}} << shift);
   assign out_pulse = in_pulse & ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (in_pulse) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tps_count.sv
module tps_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wrap <= 1'b0;
      end else begin
         wrap <= step & ~clr & (&cnt);
         if (clr)       cnt <= '0;
         else if (step) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/shared_tick_prescaler.sv
module shared_tick_prescaler #(
   parameter int TMR_W  = 8,
   parameter int WDT_W  = 8,
   parameter int PS_W   = 8,
   parameter int SYNC_N = 2,
   localparam int RS_W  = $clog2(PS_W),
   localparam int SH_W  = RS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             owner_wdt,
   input  logic [RS_W-1:0]  rate_sel,
   input  logic             ext_src,
   input  logic             fall_edge,
   input  logic             ext_pin,
   input  logic             wdt_tick,
   input  logic             wdt_clear,
   output logic [TMR_W-1:0] tmr_count,
   output logic             tmr_ovf,
   output logic             wdt_reset
);
   import tps_pkg::*;

   generate
      if (PS_W < 2 || (1 << RS_W) != PS_W) begin : g_bad_ps
         $error("PS_W must be a power of two of at least 2");
      end
      if (SYNC_N < 1) begin : g_bad_sync
         $error("SYNC_N must be at least 1");
      end
      if (TMR_W < 1 || WDT_W < 1) begin : g_bad_w
         $error("counter widths must be positive");
      end
   endgenerate

   tps_cfg_t        cfg_q;
   tps_cfg_t        cfg_in;
   logic [RS_W-1:0] rate_q;
   logic            cfg_chg;

   assign cfg_in  = '{owner: owner_e'(owner_wdt), ext_src: ext_src, fall: fall_edge};
   assign cfg_chg = (cfg_in != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         rate_q <= '1;
      end else begin
         cfg_q  <= cfg_in;
         rate_q <= rate_sel;
      end
   end

   logic edge_p;
   tps_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin),
      .fall  (cfg_q.fall),
      .hold  (cfg_chg),
      .pulse (edge_p)
   );

   logic to_tmr, src_p, wtk_p;
   assign to_tmr = (cfg_q.owner == OWNER_TMR);
   assign src_p  = ~cfg_chg & (cfg_q.ext_src ? edge_p : 1'b1);
   assign wtk_p  = ~cfg_chg & wdt_tick;

   logic [SH_W-1:0] shift;
   assign shift = to_tmr ? ({1'b0, rate_q} + {{RS_W{1'b0}}, 1'b1}) : {1'b0, rate_q};

   logic ps_in, ps_out;
   assign ps_in = to_tmr ? src_p : wtk_p;

   tps_divider #(.PS_W(PS_W), .SH_W(SH_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cfg_chg | wdt_clear),
      .in_pulse  (ps_in),
      .shift     (shift),
      .out_pulse (ps_out)
   );

   logic tmr_step, wdt_step;
   assign tmr_step = to_tmr ? ps_out : src_p;
   assign wdt_step = to_tmr ? wtk_p  : ps_out;

   tps_count #(.W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .step  (tmr_step),
      .cnt   (tmr_count),
      .wrap  (tmr_ovf)
   );

   logic [WDT_W-1:0] wdt_cnt;
   tps_count #(.W(WDT_W)) u_wdt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wdt_clear),
      .step  (wdt_step),
      .cnt   (wdt_cnt),
      .wrap  (wdt_reset)
   );
endmodule

module tps_checker #(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chg,
   input logic             wdt_clear,
   input logic [TMR_W-1:0] tmr_count,
   input logic             tmr_ovf,
   input logic             wdt_reset
);
   // R6
   wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset);
   // R2
   ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |-> (tmr_count == '0));
   // R8
   reassign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> ($stable(tmr_count) && !tmr_ovf && !wdt_reset));
   // R7
   clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clear |=> !wdt_reset);
endmodule

bind shared_tick_prescaler tps_checker #(.TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chg       (cfg_chg),
   .wdt_clear (wdt_clear),
   .tmr_count (tmr_count),
   .tmr_ovf   (tmr_ovf),
   .wdt_reset (wdt_reset)
);

// File: tb/tb_shared_tick_prescaler.sv
module tb_shared_tick_prescaler;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       owner_wdt, ext_src, fall_edge, ext_pin, wdt_tick, wdt_clear;
   logic [2:0] rate_sel;
   logic [7:0] tmr_count;
   logic       tmr_ovf, wdt_reset;

   int vectors = 0;
   int miscompares = 0;
   int ovf_seen = 0;
   int wdt_seen = 0;

   always #4 clk = ~clk;

   shared_tick_prescaler dut (
      .clk(clk), .rst_n(rst_n), .owner_wdt(owner_wdt), .rate_sel(rate_sel),
      .ext_src(ext_src), .fall_edge(fall_edge), .ext_pin(ext_pin),
      .wdt_tick(wdt_tick), .wdt_clear(wdt_clear),
      .tmr_count(tmr_count), .tmr_ovf(tmr_ovf), .wdt_reset(wdt_reset)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (tmr_ovf)   ovf_seen++;
         if (wdt_reset) wdt_seen++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setcfg(input logic own, input logic ext, input logic fe, input logic [2:0] r);
      @(negedge clk);
      owner_wdt = own; ext_src = ext; fall_edge = fe; rate_sel = r;
      idle(3);
   endtask

   task automatic clear_wdt();
      @(negedge clk); wdt_clear = 1'b1;
      @(negedge clk); wdt_clear = 1'b0;
      idle(1);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wdt_tick = 1'b1;
         @(negedge clk); wdt_tick = 1'b0;
      end
      idle(3);
   endtask

   task automatic pin_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_pin = 1'b1; idle(3);
         ext_pin = 1'b0; idle(3);
      end
      idle(4);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      owner_wdt = 1'b1; ext_src = 1'b1; fall_edge = 1'b0; rate_sel = 3'd7;
      ext_pin = 1'b0; wdt_tick = 1'b0; wdt_clear = 1'b0;
      idle(4);
      chk("R1 count in reset", tmr_count, 0);
      chk("R1 ovf in reset", tmr_ovf, 0);
      chk("R1 wdt_reset in reset", wdt_reset, 0);
      rst_n = 1'b1;
      idle(4);
      chk("R1 count after release", tmr_count, 0);
      chk("R1 no time-out after release", wdt_seen, 0);
   endtask

   task automatic t_internal();
      int c0, o0;
      setcfg(1'b1, 1'b0, 1'b0, 3'd0);
      c0 = tmr_count;
      idle(10);
      chk("R2 R9 ten cycles undivided", (tmr_count - c0) & 255, 10);
      o0 = ovf_seen; c0 = tmr_count;
      idle(256);
      chk("R2 one overflow per 256 cycles", ovf_seen - o0, 1);
      chk("R2 count after full lap", (tmr_count - c0) & 255, 0);
   endtask

   task automatic t_tmr_div();
      int c0;
      setcfg(1'b0, 1'b0, 1'b0, 3'd0);
      c0 = tmr_count; idle(256);
      chk("R3 rate0 gives /2", (tmr_count - c0) & 255, 128);
      setcfg(1'b0, 1'b0, 1'b0, 3'd2);
      c0 = tmr_count; idle(256);
      chk("R3 rate2 gives /8", (tmr_count - c0) & 255, 32);
      setcfg(1'b0, 1'b1, 1'b0, 3'd1);
      clear_wdt();
      c0 = tmr_count;
      pin_pulses(9);
      chk("R3 R7 nine pin edges /4", (tmr_count - c0) & 255, 2);
      pin_pulses(3);
      chk("R3 twelve pin edges /4", (tmr_count - c0) & 255, 3);
   endtask

   task automatic t_edges();
      int c0;
      setcfg(1'b1, 1'b1, 1'b0, 3'd0);
      c0 = tmr_count;
      @(negedge clk); ext_pin = 1'b1; idle(5);
      chk("R4 R9 rising counted", (tmr_count - c0) & 255, 1);
      ext_pin = 1'b0; idle(5);
      chk("R4 falling ignored in rising mode", (tmr_count - c0) & 255, 1);
      setcfg(1'b1, 1'b1, 1'b1, 3'd0);
      c0 = tmr_count;
      @(negedge clk); ext_pin = 1'b1; idle(5);
      chk("R4 rising ignored in falling mode", (tmr_count - c0) & 255, 0);
      ext_pin = 1'b0; idle(5);
      chk("R4 falling counted", (tmr_count - c0) & 255, 1);
   endtask

   task automatic t_wdt_div();
      int w0;
      setcfg(1'b1, 1'b0, 1'b0, 3'd0);
      clear_wdt(); w0 = wdt_seen;
      ticks(255);
      chk("R5 R6 255 ticks at 1:1", wdt_seen - w0, 0);
      ticks(1);
      chk("R5 R6 256th tick at 1:1", wdt_seen - w0, 1);
      setcfg(1'b1, 1'b0, 1'b0, 3'd2);
      clear_wdt(); w0 = wdt_seen;
      ticks(1023);
      chk("R5 1023 ticks at 1:4", wdt_seen - w0, 0);
      ticks(1);
      chk("R5 R6 1024th tick at 1:4", wdt_seen - w0, 1);
   endtask

   task automatic t_timer_owner();
      int w0;
      setcfg(1'b0, 1'b1, 1'b0, 3'd7);
      clear_wdt(); w0 = wdt_seen;
      ticks(255);
      chk("R9 watchdog undivided, 255 ticks", wdt_seen - w0, 0);
      ticks(1);
      chk("R9 watchdog undivided, 256 ticks", wdt_seen - w0, 1);
   endtask

   task automatic t_clear();
      int w0;
      setcfg(1'b1, 1'b0, 1'b0, 3'd0);
      clear_wdt(); w0 = wdt_seen;
      ticks(200);
      clear_wdt();
      ticks(200);
      chk("R7 clear restarts watchdog", wdt_seen - w0, 0);
      ticks(56);
      chk("R7 time-out 256 after clear", wdt_seen - w0, 1);
   endtask

   task automatic t_reassign();
      int w0, c0;
      setcfg(1'b1, 1'b1, 1'b0, 3'd0);
      clear_wdt(); w0 = wdt_seen;
      ticks(255);
      @(negedge clk); ext_pin = 1'b1; idle(5);
      c0 = tmr_count;
      setcfg(1'b0, 1'b1, 1'b1, 3'd0);
      setcfg(1'b1, 1'b1, 1'b1, 3'd0);
      setcfg(1'b0, 1'b1, 1'b0, 3'd0);
      setcfg(1'b1, 1'b1, 1'b0, 3'd0);
      chk("R8 no time-out, pin high", wdt_seen - w0, 0);
      chk("R8 timer still, pin high", (tmr_count - c0) & 255, 0);
      setcfg(1'b1, 1'b1, 1'b1, 3'd0);
      @(negedge clk); ext_pin = 1'b0; idle(5);
      c0 = tmr_count;
      setcfg(1'b1, 1'b1, 1'b0, 3'd0);
      setcfg(1'b0, 1'b1, 1'b0, 3'd0);
      setcfg(1'b1, 1'b1, 1'b0, 3'd0);
      setcfg(1'b0, 1'b1, 1'b1, 3'd0);
      setcfg(1'b1, 1'b1, 1'b1, 3'd0);
      chk("R8 no time-out, pin low", wdt_seen - w0, 0);
      chk("R8 timer still, pin low", (tmr_count - c0) & 255, 0);
      ticks(1);
      chk("R8 one real tick still times out", wdt_seen - w0, 1);
   endtask

   initial begin
      t_reset();
      t_internal();
      t_tmr_div();
      t_edges();
      t_wdt_div();
      t_timer_owner();
      t_clear();
      t_reassign();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(8 * 200000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule